// File: doc/BRIEF.md
# Sequence-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. A 32-bit counter counts upward on a tick-enable input, which stands for the slow timer clock. It may pass through a power-of-two prescaler first. Software keeps the system alive by writing a new value to a trigger register. A changed trigger value reloads the counter from a load register. If software stops doing this, the counter runs from all ones to zero while the timer is running, and the block raises a one-cycle reset request.

Running and stopping are guarded. Each needs its own ordered pair of key words written to a key register. Writes to the control, load, trigger and key registers are posted. Each write is held in a per-register slot and takes effect on the next tick. A pending register reports one busy flag per slot, and software polls it before writing that register again. The whole block runs on one clock. The slow domain is represented only by the tick enable.

Top module: `wdt_seq_timer`

## Requirements
- R1: After reset the timer is stopped. The counter, the control register and the pending register all read 0, and `rst_req` is low.
- R2: Address 0 returns the revision code `REV_CODE` in bits 7:0, with all upper bits 0. Address 1 holds one read/write bit in bit 0, which is written at once and not posted. Its other bits read 0.
- R3: Writes to control (address 2), load (4), trigger (5) and key (6) are posted. The pending register (address 7) shows a busy flag for each one: bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for key. A flag sets on the write and clears on the next tick, when the value is applied. Control and load read back the applied value.
- R4: A write to a posted register whose busy flag is set is dropped.
- R5: An applied trigger value that differs from the last applied trigger value copies the load value into the counter. The last trigger value is 0 after reset. A trigger value equal to the last one has no effect.
- R6: The key word 0xBBBB followed by 0x4444 (bits 15:0 of the key register) starts the timer. Counting begins on the tick after the second word is applied.
- R7: The key word 0xAAAA followed by 0x5555 stops the timer. The tick that applies the second word still counts.
- R8: Any key word that is not the expected next word of a sequence clears the partial sequence. A second word with no matching first word is ignored.
- R9: The counter changes only on ticks. While stopped it holds its value. While running, with control bit 5 clear, it advances by one each tick. With bit 5 set, it advances once every 2^ratio ticks, where ratio is control bits 4:2.
- R10: When the running counter steps from all ones, it wraps to 0 and `rst_req` pulses high for exactly one cycle.
- R11: If a reload and a step fall on the same tick, the reload wins, and no reset request is raised even when the counter was at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_en | input | 1 | Slow timer tick enable |
| rst_req | output | 1 | Reset request pulse on timeout |

## Verification
Two functions can land on the same tick: a trigger reload and a counter step from all ones, which would otherwise wrap and request a reset. The bench lets the running counter reach all ones, posts a changed trigger value, and then issues the single tick that both applies the trigger and would step the counter. That tick passes when the counter reads the load value and the reset-pulse count is unchanged. A second coincidence, a key commit and a count step on one tick, is judged by the counter value after the start and stop sequences.

// File: rtl/wdt_seq_pkg.sv
// Package: shared register addresses, key words and pending-bit positions
// for the sequence-protected watchdog timer.
package wdt_seq_pkg;

    localparam int ADDR_W   = 3;
    localparam int RATIO_W  = 3;   // prescaler ratio field width (ctrl 4:2)
    localparam int NSLOT    = 4;   // posted-write slots

    typedef enum logic [ADDR_W-1:0] {
        A_REV    = 3'd0,
        A_SYSCFG = 3'd1,
        A_CTRL   = 3'd2,
        A_COUNT  = 3'd3,
        A_LOAD   = 3'd4,
        A_TRIG   = 3'd5,
        A_KEY    = 3'd6,
        A_PEND   = 3'd7
    } reg_addr_e;

    // Slot indices of the posted registers
    localparam int S_CTRL = 0;
    localparam int S_LOAD = 1;
    localparam int S_TRIG = 2;
    localparam int S_KEY  = 3;

    // Control field positions
    localparam int PRE_EN_BIT = 5;
    localparam int RATIO_LSB  = 2;

    // Key words
    localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
    localparam logic [15:0] KEY_RUN_B  = 16'h4444;
    localparam logic [15:0] KEY_STOP_A = 16'hAAAA;
    localparam logic [15:0] KEY_STOP_B = 16'h5555;

    // Bus address that each posted slot answers to
    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            S_CTRL:  return A_CTRL;
            S_LOAD:  return A_LOAD;
            S_TRIG:  return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction

endpackage

// File: rtl/wdt_post_slot.sv
// Module: one posted-write slot. Captures a bus write while idle, raises
// busy, and on the next tick emits a one-cycle commit and frees itself.
// Assumes: a write arriving while busy is dropped, even on the commit edge.
module wdt_post_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              tick_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              commit,
    output logic [DATA_W-1:0] shadow
);

    assign commit = busy & tick_en;

    // Hold the posted value until the tick applies it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            shadow <= '0;
        end else if (commit) begin
            busy   <= 1'b0;
        end else if (wr_hit && !busy) begin
            busy   <= 1'b1;
            shadow <= wdata;
        end
    end

endmodule

// File: rtl/wdt_key_fsm.sv
// Module: run/stop key sequencer. A first word arms a direction; only the
// matching second word completes it. Any other word disarms.
// Assumes: words arrive as one-cycle commits; only bits 15:0 are compared.
module wdt_key_fsm
    import wdt_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  logic [15:0] word,
    output logic        run
);

    typedef enum logic [1:0] {K_IDLE, K_ARM_RUN, K_ARM_STOP} key_state_e;
    key_state_e state_q;

    // Advance the sequence and the run flag on each committed key word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= K_IDLE;
            run     <= 1'b0;
        end else if (commit) begin
            state_q <= K_IDLE;
            if (word == KEY_RUN_A) begin
                state_q <= K_ARM_RUN;
            end else if (word == KEY_STOP_A) begin
                state_q <= K_ARM_STOP;
            end else if (word == KEY_RUN_B && state_q == K_ARM_RUN) begin
                run <= 1'b1;
            end else if (word == KEY_STOP_B && state_q == K_ARM_STOP) begin
                run <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdt_count_core.sv
// Module: prescaler and up-counter. Steps on ticks while running; a reload
// overrides the step; a step from all ones wraps and pulses wrap_pulse.
// Assumes: reload is already qualified by a tick.
module wdt_count_core #(
    parameter int CNT_W   = 32,
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               run,
    input  logic               pre_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               reload,
    input  logic [CNT_W-1:0]   reload_val,
    output logic [CNT_W-1:0]   count,
    output logic               wrap_pulse
);

    localparam int DIV_W = (2 ** RATIO_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic             div_done;
    logic             step;

    assign div_lim  = ~({DIV_W{1'b1}} << ratio);
    assign div_done = !pre_en || (div_q >= div_lim);
    assign step     = tick_en && run && div_done;

    // Prescaler: count ticks up to 2^ratio-1, idle at 0 when bypassed
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (tick_en && run)
            div_q <= div_done ? '0 : div_q + 1'b1;
    end

    // Counter with reload priority and wrap detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= step && !reload && (&count);
            if (reload)
                count <= reload_val;
            else if (step)
                count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_seq_timer.sv
// Module: watchdog timer top. Decodes the register bus, routes posted writes
// through four slots, applies control/load/trigger on commit and reads back.
// Assumes: single clock; tick_en marks the slow-domain update instants.
module wdt_seq_timer
    import wdt_seq_pkg::*;
#(
    parameter int         DATA_W   = 32,
    parameter logic [7:0] REV_CODE = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              rst_req
);

    logic [NSLOT-1:0]  hit, busy, commit;
    logic [DATA_W-1:0] shadow [NSLOT];

    logic               pre_en_q;
    logic [RATIO_W-1:0] ratio_q;
    logic [DATA_W-1:0]  load_q;
    logic [DATA_W-1:0]  last_trig_q;
    logic               autogate_q;
    logic               run_q;
    logic [DATA_W-1:0]  count_q;
    logic [4:0]         pend_bits;
    logic               reload;
    logic [DATA_W-1:0]  reload_val;
    logic               unused_bits;

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            assign hit[i] = bus_wr && (bus_addr == slot_addr(i));
            wdt_post_slot #(.DATA_W(DATA_W)) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (hit[i]),
                .tick_en(tick_en),
                .wdata  (bus_wdata),
                .busy   (busy[i]),
                .commit (commit[i]),
                .shadow (shadow[i])
            );
        end
    endgenerate

    assign pend_bits  = {busy[S_KEY], busy[S_TRIG], busy[S_LOAD], 1'b0, busy[S_CTRL]};
    assign reload_val = commit[S_LOAD] ? shadow[S_LOAD] : load_q;
    assign reload     = commit[S_TRIG] && (shadow[S_TRIG] != last_trig_q);
    assign unused_bits = ^{shadow[S_CTRL][DATA_W-1:PRE_EN_BIT+1],
                           shadow[S_CTRL][RATIO_LSB-1:0],
                           shadow[S_KEY][DATA_W-1:16]};

    // Apply committed control, load and trigger values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_en_q    <= 1'b0;
            ratio_q     <= '0;
            load_q      <= '0;
            last_trig_q <= '0;
        end else begin
            if (commit[S_CTRL]) begin
                pre_en_q <= shadow[S_CTRL][PRE_EN_BIT];
                ratio_q  <= shadow[S_CTRL][RATIO_LSB +: RATIO_W];
            end
            if (commit[S_LOAD])
                load_q <= shadow[S_LOAD];
            if (commit[S_TRIG])
                last_trig_q <= shadow[S_TRIG];
        end
    end

    // Direct (non-posted) configuration bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            autogate_q <= 1'b0;
        else if (bus_wr && bus_addr == A_SYSCFG)
            autogate_q <= bus_wdata[0];
    end

    wdt_key_fsm u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(commit[S_KEY]),
        .word  (shadow[S_KEY][15:0]),
        .run   (run_q)
    );

    wdt_count_core #(.CNT_W(DATA_W), .RATIO_W(RATIO_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (run_q),
        .pre_en    (pre_en_q),
        .ratio     (ratio_q),
        .reload    (reload),
        .reload_val(reload_val),
        .count     (count_q),
        .wrap_pulse(rst_req)
    );

    // Register readback mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_REV:    bus_rdata[7:0] = REV_CODE;
            A_SYSCFG: bus_rdata[0]   = autogate_q;
            A_CTRL: begin
                bus_rdata[PRE_EN_BIT]             = pre_en_q;
                bus_rdata[RATIO_LSB +: RATIO_W]   = ratio_q;
            end
            A_COUNT:  bus_rdata = count_q;
            A_LOAD:   bus_rdata = load_q;
            A_PEND:   bus_rdata[4:0] = pend_bits;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_seq_timer_chk.sv
// Module: property checker for wdt_seq_timer, attached by bind.
// Assumes: signals sampled on clk; reset synchronous active-low.
module wdt_seq_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_wr,
    input logic              rst_req,
    input logic              run,
    input logic [DATA_W-1:0] count,
    input logic [4:0]        pend
);

    // R10: reset request lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R10: the pulse coincides with the wrapped counter
    a_r10_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == '0));

    // R3: a tick with no new write leaves nothing pending
    a_r3_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !bus_wr) |=> (pend == 5'd0));

    // R9: counter moves only on ticks
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

    // R9: stopped and no trigger pending means no change
    a_r9_off_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !pend[3]) |=> $stable(count));

    // R6: the timer starts only on a tick
    a_r6_run_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(tick_en));

endmodule

bind wdt_seq_timer wdt_seq_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .bus_wr (bus_wr),
    .rst_req(rst_req),
    .run    (run_q),
    .count  (count_q),
    .pend   (pend_bits)
);

// File: tb/wdt_seq_timer_bench.sv
`timescale 1ns/1ps
module wdt_seq_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int cyc = 0;
    bit done = 0;
    logic mon_req = 1'b0;

    typedef struct {
        logic [2:0]  a;
        logic [31:0] e;
        string       tag;
    } exp_t;
    exp_t q[$];
    exp_t it;

    wdt_seq_timer u_wdt_seq_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .rst_req(rst_req)
    );

    always #10 clk = ~clk;

    // Monitor: pop expected reads and compare mid-cycle
    always @(negedge clk) begin
        if (mon_req && q.size() > 0) begin
            it = q.pop_front();
            total++;
            if (bus_rdata !== it.e) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, bus_rdata, it.e);
            end
        end
        if (rst_n && rst_req) pulses++;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2; tick_en = 1'b1;
            @(posedge clk); #2; tick_en = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #2;
        bus_addr = a;
        q.push_back('{a, e, tag});
        mon_req = 1'b1;
        @(posedge clk); #2;
        mon_req = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd(3'd3, 32'h0, "R1 count");
        rd(3'd7, 32'h0, "R1 pend");
        rd(3'd2, 32'h0, "R1 ctrl");
        chk("R1 rst_req", int'(rst_req), 0);
        // R2 revision
        rd(3'd0, 32'h0000_0021, "R2 rev");
        // R3 / R4 posting and drop
        wr(3'd4, 32'hFFFF_FFF8);
        rd(3'd7, 32'h0000_0004, "R3 load busy");
        wr(3'd4, 32'h0000_0001);
        tick(1);
        rd(3'd7, 32'h0, "R3 busy cleared");
        rd(3'd4, 32'hFFFF_FFF8, "R4 dropped write");
        // R5 reload on changed trigger
        wr(3'd5, 32'h0000_1234); tick(1);
        rd(3'd3, 32'hFFFF_FFF8, "R5 reload");
        // R9 stopped holds
        tick(3);
        rd(3'd3, 32'hFFFF_FFF8, "R9 stopped hold");
        // R8 broken sequences
        wr(3'd6, 32'h0000_4444); tick(1);
        wr(3'd6, 32'h0000_BBBB); tick(1);
        wr(3'd6, 32'h0000_1111); tick(1);
        wr(3'd6, 32'h0000_4444); tick(1);
        tick(2);
        rd(3'd3, 32'hFFFF_FFF8, "R8 still stopped");
        // R6 start
        wr(3'd6, 32'h0000_BBBB); tick(1);
        wr(3'd6, 32'h0000_4444); tick(1);
        rd(3'd3, 32'hFFFF_FFF8, "R6 no step on start tick");
        tick(1);
        rd(3'd3, 32'hFFFF_FFF9, "R6 counting");
        // R9 prescaler ratio 2
        wr(3'd2, 32'h0000_0028); tick(1);
        rd(3'd2, 32'h0000_0028, "R3 ctrl readback");
        rd(3'd3, 32'hFFFF_FFFA, "R9 old ctrl tick");
        tick(3);
        rd(3'd3, 32'hFFFF_FFFA, "R9 prescale wait");
        tick(1);
        rd(3'd3, 32'hFFFF_FFFB, "R9 prescale step");
        wr(3'd2, 32'h0); tick(1);
        rd(3'd3, 32'hFFFF_FFFB, "R9 prescale off tick");
        tick(1);
        rd(3'd3, 32'hFFFF_FFFC, "R9 direct step");
        // R10 overflow
        tick(3);
        rd(3'd3, 32'hFFFF_FFFF, "R10 all ones");
        chk("R10 no early pulse", pulses, 0);
        tick(1);
        repeat (2) @(posedge clk);
        rd(3'd3, 32'h0, "R10 wrap");
        chk("R10 one pulse", pulses, 1);
        // R5 same trigger ignored, changed trigger reloads
        wr(3'd5, 32'h0000_1234); tick(1);
        rd(3'd3, 32'h1, "R5 same trigger");
        wr(3'd5, 32'h0000_EDCB); tick(1);
        rd(3'd3, 32'hFFFF_FFF8, "R5 changed trigger");
        // R11 reload vs overflow
        tick(7);
        rd(3'd3, 32'hFFFF_FFFF, "R11 at all ones");
        wr(3'd5, 32'h0000_1234); tick(1);
        repeat (2) @(posedge clk);
        rd(3'd3, 32'hFFFF_FFF8, "R11 reload wins");
        chk("R11 no pulse", pulses, 1);
        // R3 several pending, R7 stop
        wr(3'd6, 32'h0000_AAAA);
        wr(3'd2, 32'h0);
        wr(3'd5, 32'h0000_1234);
        rd(3'd7, 32'h0000_0019, "R3 multi pending");
        tick(1);
        rd(3'd3, 32'hFFFF_FFF9, "R7 arm tick counts");
        wr(3'd6, 32'h0000_5555); tick(1);
        rd(3'd3, 32'hFFFF_FFFA, "R7 stop tick counts");
        tick(2);
        rd(3'd3, 32'hFFFF_FFFA, "R7 stopped");
        // R2 config bit
        wr(3'd1, 32'h0000_0003);
        rd(3'd1, 32'h1, "R2 sysconfig");
        repeat (2) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule